// File: doc/BRIEF.md
# Ethernet Receive Address Filter

The filter watches the byte stream of an incoming Ethernet frame and decides whether the frame is accepted. It uses three inputs: the destination address (the first six bytes), whether the frame reaches the minimum length of 60 bytes (the FCS is not counted), and a 16-bit receive-mode word. For an accepted frame it also produces a status word that marks it as multicast or broadcast. A receive engine downstream uses the verdict to drop the frame or store it, and copies the status bits into its receive descriptor.

The rules are checked in a fixed order, and the first one that applies decides:

1. A short frame is settled by the runt-accept mode bit.
2. In promiscuous mode, any unicast destination is accepted.
3. In all-multicast mode, any group destination is accepted.
4. In broadcast mode, the all-ones destination is accepted.
5. Otherwise, the destination is compared in parallel against an address table of 16 entries of 48 bits each. An entry takes part only when its bit in the enable mask is set.

The host loads table entries and the mask through plain write strobes. While the block is held in its configuration (hold) mode, the host can read any entry back as 16-bit words.

Frame bytes enter on a valid/ready stream. A byte transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_last` marks the final byte of a frame. `in_ready` is low for exactly as long as `hold_mode` is high. During that time no byte is consumed, and the position inside the frame is kept. The verdict has no back-pressure: `dec_valid` is a single-cycle pulse.

Top module: `rxf_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_status` are 0 and the enable mask is all zero, so no table entry can match.
- R2: A frame shorter than 60 bytes is rejected unless mode bit 14 (runt accept) is set, in which case it is accepted with status 0. This rule is checked before all others.
- R3: With mode bit 12 (promiscuous) set, a frame whose first byte has bit 0 clear is accepted with status 0.
- R4: With mode bit 11 (all multicast) set, a frame whose first byte has bit 0 set is accepted with status 0x0100 (bit 8).
- R5: With mode bit 13 (broadcast) set, a destination of six 0xFF bytes is accepted with status 0x0080 (bit 7).
- R6: The rules apply in the order R2, R3, R4, R5, R7, and only the first applicable rule decides. For example, broadcast with all-multicast also set reports 0x0100.
- R7: If no earlier rule applies, the frame is accepted with status 0 exactly when the destination equals an entry whose mask bit is set. Table byte 0 (bits 7:0 of `cam_wdata`) is compared with the first frame byte. Otherwise the frame is rejected.
- R8: Exactly one `dec_valid` pulse is produced per frame. It comes in the cycle after the transfer of byte 60, or after the transfer of the last byte of a shorter frame.
- R9: While `hold_mode` is high, `cam_rd_data` returns bytes {2w+1, 2w} of entry `cam_rd_idx`, where w is `cam_rd_word` (0 to 2), low byte in bits 7:0. At all other times `cam_rd_data` reads 0.
- R10: While `hold_mode` is high, `in_ready` is low and bytes offered on the stream are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_mode | input | 1 | Configuration hold: stalls the stream and enables table read-back |
| mode_bits | input | 16 | Receive-mode word (bits 11 to 14 used) |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Filter ready to take a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| cam_we | input | 1 | Table entry write strobe |
| cam_idx | input | 4 | Table entry to write |
| cam_wdata | input | 48 | Address to store, byte 0 in bits 7:0 |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | 16 | New enable mask, bit i enables entry i |
| cam_rd_idx | input | 4 | Table entry to read back |
| cam_rd_word | input | 2 | 16-bit word of that entry |
| cam_rd_data | output | 16 | Read-back word (0 outside hold mode) |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_status | output | 16 | Packet-type bits: 0x0100 multicast, 0x0080 broadcast |

## Verification
The hardest case to reach from the ports is a stream byte offered while the block is in hold mode. Such a byte must leave no trace. A wrong count would only show up later, as a verdict in the wrong cycle or with the wrong outcome. The bench therefore offers bytes during hold mode and then sends a 59-byte unicast frame in promiscuous mode. If the stalled bytes had been counted, that frame would reach 60 bytes and be accepted, and the verdict would come in a different cycle. The correct result is a rejection one cycle after the 59th byte. The priority order is covered by sweeping all 16 combinations of the four mode bits against five destination classes and four lengths, with the bench deriving each expected verdict.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MODE_W      = 16;
  localparam int STAT_W      = 16;
  localparam int RUNT_OK_BIT = 14;
  localparam int BCAST_BIT   = 13;
  localparam int PROMISC_BIT = 12;
  localparam int ALLMC_BIT   = 11;
  localparam int ST_MC_BIT   = 8;
  localparam int ST_BC_BIT   = 7;
endpackage

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture #(
  parameter int ADDR_BYTES = 6,
  parameter int MIN_LEN    = 60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_last,
  output logic [ADDR_BYTES*8-1:0] dest,
  output logic                    settle,
  output logic                    is_runt
);
  localparam int CNT_W = $clog2(MIN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MIN_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             decided;
  logic             fire;
  logic             reached;

  assign fire    = in_valid && in_ready;
  assign reached = (cnt == LAST_IDX);
  assign settle  = fire && !decided && (reached || in_last);
  assign is_runt = !reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      decided <= 1'b0;
    end else if (fire) begin
      if (in_last) begin
        cnt     <= '0;
        decided <= 1'b0;
      end else begin
        if (!reached) cnt <= cnt + 1'b1;
        if (settle) decided <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dest[b*8 +: 8] <= '0;
      end else if (fire && !decided && cnt == CNT_W'(b)) begin
        dest[b*8 +: 8] <= in_data;
      end
    end
  end

  a_r10_stall_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(cnt));

  a_r8_single_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (settle && !in_last) |=> decided);
endmodule

// File: rtl/rxf_addr_cam.sv
module rxf_addr_cam #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cam_we,
  input  logic [$clog2(ENTRIES)-1:0]  cam_idx,
  input  logic [ADDR_W-1:0]           cam_wdata,
  input  logic                        mask_we,
  input  logic [ENTRIES-1:0]          mask_wdata,
  input  logic [ADDR_W-1:0]           key,
  output logic                        hit,
  input  logic                        hold_mode,
  input  logic [$clog2(ENTRIES)-1:0]  rd_idx,
  input  logic [1:0]                  rd_word,
  output logic [15:0]                 rd_data
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int WORDS = ADDR_W / 16;

  logic [ADDR_W-1:0]  ent [ENTRIES];
  logic [ENTRIES-1:0] en_mask;
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_mask <= '0;
    else if (mask_we) en_mask <= mask_wdata;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[e] <= '0;
      else if (cam_we && cam_idx == IDX_W'(e)) ent[e] <= cam_wdata;
    end
    assign hit_vec[e] = en_mask[e] && (ent[e] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    rd_data = '0;
    if (hold_mode && int'(rd_word) < WORDS) begin
      rd_data = ent[rd_idx][int'(rd_word)*16 +: 16];
    end
  end

  a_r7_cleared_mask_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_we) && $past(mask_wdata) == '0) |-> !hit);
endmodule

// File: rtl/rxf_rule_select.sv
module rxf_rule_select
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              settle,
  input  logic              is_runt,
  input  logic [ADDR_W-1:0] dest,
  input  logic [MODE_W-1:0] mode,
  input  logic              cam_hit,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [STAT_W-1:0] dec_status
);
  logic              v_acc;
  logic [STAT_W-1:0] v_st;

  always_comb begin
    v_acc = 1'b0;
    v_st  = '0;
    if (is_runt) begin
      v_acc = mode[RUNT_OK_BIT];
    end else if (mode[PROMISC_BIT] && !dest[0]) begin
      v_acc = 1'b1;
    end else if (mode[ALLMC_BIT] && dest[0]) begin
      v_acc = 1'b1;
      v_st[ST_MC_BIT] = 1'b1;
    end else if (mode[BCAST_BIT] && (&dest)) begin
      v_acc = 1'b1;
      v_st[ST_BC_BIT] = 1'b1;
    end else begin
      v_acc = cam_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_status <= '0;
    end else begin
      dec_valid  <= settle;
      dec_accept <= settle && v_acc;
      dec_status <= settle ? v_st : '0;
    end
  end

  a_r4_type_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_status[ST_MC_BIT], dec_status[ST_BC_BIT]}));

  a_r6_typed_means_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_status != '0) |-> (dec_valid && dec_accept));

  a_r1_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_status == '0));
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
  import rxf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_BYTES  = 6,
  parameter int MIN_LEN     = 60
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hold_mode,
  input  logic [MODE_W-1:0]              mode_bits,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [7:0]                     in_data,
  input  logic                           in_last,
  input  logic                           cam_we,
  input  logic [$clog2(NUM_ENTRIES)-1:0] cam_idx,
  input  logic [ADDR_BYTES*8-1:0]        cam_wdata,
  input  logic                           mask_we,
  input  logic [NUM_ENTRIES-1:0]         mask_wdata,
  input  logic [$clog2(NUM_ENTRIES)-1:0] cam_rd_idx,
  input  logic [1:0]                     cam_rd_word,
  output logic [15:0]                    cam_rd_data,
  output logic                           dec_valid,
  output logic                           dec_accept,
  output logic [STAT_W-1:0]              dec_status
);
  localparam int ADDR_W = ADDR_BYTES * 8;

  logic [ADDR_W-1:0] dest;
  logic              settle;
  logic              is_runt;
  logic              cam_hit;

  assign in_ready = !hold_mode;

  rxf_dest_capture #(.ADDR_BYTES(ADDR_BYTES), .MIN_LEN(MIN_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .dest(dest), .settle(settle),
    .is_runt(is_runt)
  );

  rxf_addr_cam #(.ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_cam (
    .clk(clk), .rst_n(rst_n), .cam_we(cam_we), .cam_idx(cam_idx),
    .cam_wdata(cam_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .key(dest), .hit(cam_hit), .hold_mode(hold_mode), .rd_idx(cam_rd_idx),
    .rd_word(cam_rd_word), .rd_data(cam_rd_data)
  );

  rxf_rule_select #(.ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .settle(settle), .is_runt(is_runt),
    .dest(dest), .mode(mode_bits), .cam_hit(cam_hit),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_status(dec_status)
  );

  a_r8_verdict_follows_settle: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(settle));
endmodule

// File: tb/rxf_filter_tb.sv
module rxf_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LEN    = 60;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        hold_mode = 0;
  logic [15:0] mode_bits = '0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 0;
  logic        cam_we = 0;
  logic [3:0]  cam_idx = '0;
  logic [47:0] cam_wdata = '0;
  logic        mask_we = 0;
  logic [15:0] mask_wdata = '0;
  logic [3:0]  cam_rd_idx = '0;
  logic [1:0]  cam_rd_word = '0;
  logic [15:0] cam_rd_data;
  logic        dec_valid;
  logic        dec_accept;
  logic [15:0] dec_status;

  rxf_filter u_dut (
    .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .mode_bits(mode_bits),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .cam_we(cam_we), .cam_idx(cam_idx), .cam_wdata(cam_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .cam_rd_idx(cam_rd_idx), .cam_rd_word(cam_rd_word),
    .cam_rd_data(cam_rd_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_status(dec_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;
  int n_dec = 0;
  int got_cyc = 0;
  logic        got_acc;
  logic [15:0] got_st;
  logic [15:0] cur_mask = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (dec_valid) begin
      n_dec   <= n_dec + 1;
      got_acc <= dec_accept;
      got_st  <= dec_status;
      got_cyc <= cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] cam_val(input int i);
    return {8'(i * 3), 8'h3C, ~8'(i), 8'hA5, 8'(i), 8'h02};
  endfunction

  // expected verdict from the requirements; returns rule tag
  function automatic string expect_dec(input logic [47:0] d, input int len,
      input logic [15:0] m, input logic [15:0] mask,
      output logic acc, output logic [15:0] st);
    acc = 0; st = '0;
    if (len < MIN_LEN) begin acc = m[14]; return "R2"; end
    if (m[12] && !d[0]) begin acc = 1; return "R3"; end
    if (m[11] && d[0]) begin acc = 1; st = 16'h0100; return "R4"; end
    if (m[13] && d == {48{1'b1}}) begin acc = 1; st = 16'h0080; return "R5"; end
    for (int i = 0; i < 16; i++)
      if (mask[i] && cam_val(i) == d) acc = 1;
    return "R7";
  endfunction

  task automatic send_frame(input logic [47:0] d, input int len,
                            input logic [15:0] m, input string extra);
    int exp_cyc;
    logic eacc;
    logic [15:0] est;
    string rq;
    exp_cyc = -1;
    mode_bits = m;
    n_dec = 0;
    @(negedge clk);
    for (int b = 0; b < len; b++) begin
      if (b % 7 == 3) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_data  = (b < 6) ? d[b*8 +: 8] : 8'(b);
      in_last  = (b == len - 1);
      if (b == MIN_LEN - 1 || (b == len - 1 && len < MIN_LEN)) exp_cyc = cyc + 1;
      @(negedge clk);
    end
    in_valid = 0;
    in_last  = 0;
    repeat (3) @(negedge clk);
    rq = expect_dec(d, len, m, cur_mask, eacc, est);
    rq = {rq, " R6 ", extra};
    check(n_dec == 1, {"R8 ", rq}, "pulse count", 48'(n_dec), 48'd1);
    check(got_cyc == exp_cyc, {"R8 ", rq}, "verdict cycle", 48'(got_cyc), 48'(exp_cyc));
    check(got_acc == eacc, rq, "accept", 48'(got_acc), 48'(eacc));
    check(got_st == est, rq, "status", 48'(got_st), 48'(est));
  endtask

  task automatic cam_write(input int i, input logic [47:0] v);
    cam_we = 1; cam_idx = 4'(i); cam_wdata = v;
    @(negedge clk);
    cam_we = 0;
  endtask

  task automatic mask_load(input logic [15:0] m);
    mask_we = 1; mask_wdata = m;
    @(negedge clk);
    mask_we = 0;
    cur_mask = m;
  endtask

  function automatic logic [47:0] dest_of(input int dt, input int k);
    case (dt)
      0: return {8'h11, 8'h22, 8'h33, 8'h44, 8'h77, 8'h02};
      1: return cam_val(2 * (k % 8));
      2: return cam_val(2 * (k % 8) + 1);
      3: return {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
      default: return {48{1'b1}};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dec_valid == 0, "R1", "dec_valid in reset", 48'(dec_valid), 48'd0);
    check(dec_status == 0 && dec_accept == 0, "R1", "verdict in reset",
          48'({dec_accept, dec_status}), 48'd0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1, "R10", "ready out of hold", 48'(in_ready), 48'd1);
    // R1: mask resets to zero so a table entry cannot match
    hold_mode = 1;
    cam_write(0, cam_val(0));
    hold_mode = 0;
    send_frame(cam_val(0), 60, 16'h0000, "R1 mask clear");

    // R9: load and read back in hold
    hold_mode = 1;
    @(negedge clk);
    check(in_ready == 0, "R10", "ready in hold", 48'(in_ready), 48'd0);
    for (int i = 0; i < 16; i++) cam_write(i, cam_val(i));
    for (int i = 0; i < 16; i++) begin
      for (int w = 0; w < 3; w++) begin
        logic [47:0] v;
        v = cam_val(i);
        cam_rd_idx = 4'(i); cam_rd_word = 2'(w);
        #1;
        check(cam_rd_data == v[w*16 +: 16], "R9", "read-back word",
              48'(cam_rd_data), 48'(v[w*16 +: 16]));
      end
    end
    hold_mode = 0;
    cam_rd_idx = 4'd5; cam_rd_word = 2'd1;
    #1;
    check(cam_rd_data == 16'h0000, "R9", "read outside hold", 48'(cam_rd_data), 48'd0);
    @(negedge clk);

    // R10: bytes offered in hold are not counted
    hold_mode = 1;
    for (int k = 0; k < 10; k++) begin
      in_valid = 1; in_data = 8'hEE; in_last = 0;
      @(negedge clk);
    end
    in_valid = 0;
    hold_mode = 0;
    cur_mask = 16'h0000;
    send_frame(dest_of(0, 0), 59, 16'h1000, "R10 stalled bytes");

    // R7: each entry alone against every address
    for (int m = 0; m < 16; m++) begin
      mask_load(16'(1 << m));
      for (int e = 0; e < 16; e++) send_frame(cam_val(e), 60, 16'h0000, "R7 mask sweep");
    end
    mask_load(16'hFFFF);
    send_frame(dest_of(0, 0), 64, 16'h0000, "R7 no match");

    // R2..R6: mode x destination x length sweep
    mask_load(16'h5555);
    for (int md = 0; md < 16; md++) begin
      logic [15:0] m;
      m = 16'h0021;
      if (md[0]) m[14] = 1;
      if (md[1]) m[12] = 1;
      if (md[2]) m[11] = 1;
      if (md[3]) m[13] = 1;
      for (int dt = 0; dt < 5; dt++) begin
        send_frame(dest_of(dt, md), 3,  m, "sweep");
        send_frame(dest_of(dt, md), 59, m, "sweep");
        send_frame(dest_of(dt, md), 60, m, "sweep");
        send_frame(dest_of(dt, md), 75, m, "sweep");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule